// File: doc/BRIEF.md
# Motion Activity and Quiet-Period Detector

This block watches a stream of three-axis acceleration samples and raises two kinds of event. An activity event marks a sample on which at least one selected axis moved harder than a programmable limit. A quiet event marks the end of a period in which every selected axis stayed under a second limit for a programmable number of seconds. Each function has its own axis selection. Each can judge either the raw magnitude of the sample (dc) or how far the sample has moved from a reference taken when the function was switched on (ac).

Samples arrive with a one-cycle strobe. The seconds base comes from an external one-cycle tick. Both limits are 8-bit unsigned codes that are scaled up by a fixed shift before they are compared with sample magnitudes. Each event is a single-cycle pulse in the cycle after the deciding strobe. The axes that caused the latest activity event are held on a source output until the next activity event. After a quiet event the quiet function stays silent until an activity event has been seen.

Top module: `mad_motion_detect`

## Requirements
- R1: After reset both event outputs are 0 and the activity source output is 0.
- R2: On a sample strobe, the activity event pulses in the next cycle when the magnitude of any selected axis is strictly greater than the activity code shifted left by THR_SHIFT. A magnitude equal to that limit gives no event.
- R3: The activity source output uses bit 2 for X, bit 1 for Y and bit 0 for Z. On each activity event it loads exactly the selected axes that went over the limit, and it holds that value until the next activity event. Unselected axes never set a bit and never cause an event.
- R4: The configuration byte is read as follows. Bit 7 picks ac mode for activity and bits 6:4 select X, Y and Z for activity. Bit 3 picks ac mode for quiet detection and bits 2:0 select X, Y and Z for quiet detection.
- R5: In dc mode the magnitude is the absolute value of the two's-complement sample, so negative samples are judged by their size.
- R6: In ac mode a function captures its reference on the first sample strobe after it has ac mode set and at least one axis selected. On that sample its magnitude is 0. On later samples the magnitude is the absolute difference from the reference. Leaving that state and entering it again causes a fresh capture.
- R7: A sample is quiet when every axis selected for quiet detection has a magnitude strictly below the quiet code shifted left by THR_SHIFT. A sample on which any selected axis is at or above that limit restarts the seconds count.
- R8: The seconds count advances by one for each tick that arrives after a quiet sample, and saturates. A quiet event is decided only on a sample strobe: a quiet sample with a count at or above the programmed seconds produces it. A tick alone never produces an event.
- R9: With a seconds setting of 0, the first quiet sample produces a quiet event at once.
- R10: After a quiet event, no further quiet event occurs until an activity event has occurred. An activity event also restarts the seconds count.
- R11: A function with no axis selected never produces its event.
- R12: Each event is high for exactly the cycle after the strobe that decided it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | One-cycle strobe marking a new sample |
| smp_x_i | input | DATA_W | X acceleration, two's complement |
| smp_y_i | input | DATA_W | Y acceleration, two's complement |
| smp_z_i | input | DATA_W | Z acceleration, two's complement |
| motion_cfg_i | input | 2*(AXES+1) | Mode and axis selection byte (see R4) |
| act_thr_i | input | THR_W | Activity limit code |
| quiet_thr_i | input | THR_W | Quiet limit code |
| quiet_secs_i | input | TIME_W | Seconds of quiet required before a quiet event |
| sec_tick_i | input | 1 | One-cycle tick once per second |
| act_evt_o | output | 1 | Activity event pulse |
| quiet_evt_o | output | 1 | Quiet event pulse |
| act_src_o | output | AXES | Axes behind the latest activity event |

## Verification
The bench puts samples exactly on each limit, because a design that uses the wrong comparison would fire activity at equality or treat an equal quiet sample as quiet. It checks negative samples, which a design that skips the absolute value would never see as active. It also checks ac references across a disable and re-enable, where a design that keeps a stale reference would fire on the first sample. For the quiet path it interleaves ticks with loud and quiet samples and checks for an event on each strobe. A counter that is not restarted by loud samples, that counts ticks before the first quiet sample, or that fires on a tick would each produce an event at the wrong point. Re-arming is checked by sending quiet samples after a quiet event, where a design without the arming latch would pulse again.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam int AXES = 3;

  // one function's slice of the configuration byte
  typedef struct packed {
    logic            ac;
    logic [AXES-1:0] en;  // [2]=X [1]=Y [0]=Z
  } fn_cfg_t;

  localparam int CFG_W = 2 * (AXES + 1);
endpackage

// File: rtl/mad_axis_mag.sv
module mad_axis_mag #(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic                     use_ref_i,
  output logic        [DATA_W:0]   mag_o
);
  localparam int MAG_W = DATA_W + 1;

  logic signed [MAG_W-1:0] diff;

  always_comb begin
    if (use_ref_i) diff = MAG_W'(sample_i) - MAG_W'(ref_i);
    else           diff = MAG_W'(sample_i);
    if (diff[MAG_W-1]) mag_o = MAG_W'(-diff);
    else               mag_o = MAG_W'(diff);
  end
endmodule

// File: rtl/mad_ref_bank.sv
module mad_ref_bank
  import mad_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             smp_valid_i,
  input  fn_cfg_t                          cfg_i,
  input  logic [AXES-1:0][DATA_W-1:0]      smp_i,
  output logic [AXES-1:0][DATA_W-1:0]      ref_o
);
  logic live;
  logic cap_en;
  logic ref_ok_q, ref_ok_d;

  always_comb begin
    live     = cfg_i.ac && (|cfg_i.en);
    cap_en   = live && smp_valid_i && !ref_ok_q;
    ref_ok_d = live ? (ref_ok_q | smp_valid_i) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_ok_q <= 1'b0;
    else         ref_ok_q <= ref_ok_d;
  end

  for (genvar g = 0; g < AXES; g++) begin : g_ref
    logic [DATA_W-1:0] ref_q, ref_d;

    always_comb ref_d = cap_en ? smp_i[g] : ref_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ref_q <= '0;
      else         ref_q <= ref_d;
    end

    // before capture the sample is its own reference, giving magnitude 0
    assign ref_o[g] = ref_ok_q ? ref_q : smp_i[g];
  end

  // a capture strobe leaves the reference marked as held (R6)
  assert_ref_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en) |=> ref_ok_q);
endmodule

// File: rtl/mad_quiet_timer.sv
module mad_quiet_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic              fn_on_i,
  input  logic              quiet_smp_i,
  input  logic              sec_tick_i,
  input  logic              act_fire_i,
  input  logic [TIME_W-1:0] hold_secs_i,
  output logic              fire_o
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              calm_q, calm_d;
  logic              armed_q, armed_d;

  always_comb begin
    fire_o = smp_valid_i && fn_on_i && quiet_smp_i && armed_q &&
             (cnt_q >= hold_secs_i);
    calm_d = calm_q;
    cnt_d  = cnt_q;
    if (!fn_on_i) begin
      calm_d = 1'b0;
      cnt_d  = '0;
    end else if (smp_valid_i && !quiet_smp_i) begin
      calm_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (smp_valid_i) calm_d = 1'b1;
      if (sec_tick_i && calm_q && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
    if (act_fire_i) cnt_d = '0;
    if (act_fire_i)  armed_d = 1'b1;
    else if (fire_o) armed_d = 1'b0;
    else             armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      calm_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      calm_q  <= calm_d;
      armed_q <= armed_d;
    end
  end

  assert_loud_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && fn_on_i && !quiet_smp_i) |=> (cnt_q == '0 && !calm_q));

  assert_count_by_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i) |=> (cnt_q == '0 || cnt_q == $past(cnt_q)));

  assert_disarm_after_fire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !act_fire_i) |=> !armed_q);
endmodule

// File: rtl/mad_motion_detect.sv
module mad_motion_detect
  import mad_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int THR_W     = 8,
  parameter int THR_SHIFT = 4,
  parameter int TIME_W    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic signed [DATA_W-1:0] smp_x_i,
  input  logic signed [DATA_W-1:0] smp_y_i,
  input  logic signed [DATA_W-1:0] smp_z_i,
  input  logic [CFG_W-1:0]         motion_cfg_i,
  input  logic [THR_W-1:0]         act_thr_i,
  input  logic [THR_W-1:0]         quiet_thr_i,
  input  logic [TIME_W-1:0]        quiet_secs_i,
  input  logic                     sec_tick_i,
  output logic                     act_evt_o,
  output logic                     quiet_evt_o,
  output logic [AXES-1:0]          act_src_o
);
  localparam int CMP_W = ((DATA_W + 1) > (THR_W + THR_SHIFT)) ?
                         (DATA_W + 1) : (THR_W + THR_SHIFT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  fn_cfg_t act_cfg, qt_cfg;
  assign act_cfg = motion_cfg_i[CFG_W-1 -: AXES+1];
  assign qt_cfg  = motion_cfg_i[AXES:0];

  logic [AXES-1:0][DATA_W-1:0] smp_all, act_ref, qt_ref;
  assign smp_all = {smp_x_i, smp_y_i, smp_z_i};

  mad_ref_bank #(.DATA_W(DATA_W)) u_act_ref (
    .clk_i(clk_i), .rst_ni(rst_s), .smp_valid_i(smp_valid_i),
    .cfg_i(act_cfg), .smp_i(smp_all), .ref_o(act_ref)
  );

  mad_ref_bank #(.DATA_W(DATA_W)) u_qt_ref (
    .clk_i(clk_i), .rst_ni(rst_s), .smp_valid_i(smp_valid_i),
    .cfg_i(qt_cfg), .smp_i(smp_all), .ref_o(qt_ref)
  );

  logic [CMP_W-1:0] act_lim, qt_lim;
  assign act_lim = CMP_W'(act_thr_i) << THR_SHIFT;
  assign qt_lim  = CMP_W'(quiet_thr_i) << THR_SHIFT;

  logic [AXES-1:0] act_hit, qt_loud;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [DATA_W:0] a_mag, q_mag;

    mad_axis_mag #(.DATA_W(DATA_W)) u_act_mag (
      .sample_i(smp_all[g]), .ref_i(act_ref[g]),
      .use_ref_i(act_cfg.ac), .mag_o(a_mag)
    );

    mad_axis_mag #(.DATA_W(DATA_W)) u_qt_mag (
      .sample_i(smp_all[g]), .ref_i(qt_ref[g]),
      .use_ref_i(qt_cfg.ac), .mag_o(q_mag)
    );

    assign act_hit[g] = act_cfg.en[g] && (CMP_W'(a_mag) > act_lim);
    assign qt_loud[g] = qt_cfg.en[g] && (CMP_W'(q_mag) >= qt_lim);
  end

  logic act_fire, qt_fire, qt_smp_quiet, qt_on;

  assign act_fire     = smp_valid_i && (|act_hit);
  assign qt_on        = |qt_cfg.en;
  assign qt_smp_quiet = !(|qt_loud);

  mad_quiet_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_s), .smp_valid_i(smp_valid_i),
    .fn_on_i(qt_on), .quiet_smp_i(qt_smp_quiet), .sec_tick_i(sec_tick_i),
    .act_fire_i(act_fire), .hold_secs_i(quiet_secs_i), .fire_o(qt_fire)
  );

  logic            act_evt_d, quiet_evt_d;
  logic [AXES-1:0] act_src_d;

  always_comb begin
    act_evt_d   = act_fire;
    quiet_evt_d = qt_fire;
    act_src_d   = act_fire ? act_hit : act_src_o;
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      act_evt_o   <= 1'b0;
      quiet_evt_o <= 1'b0;
      act_src_o   <= '0;
    end else begin
      act_evt_o   <= act_evt_d;
      quiet_evt_o <= quiet_evt_d;
      act_src_o   <= act_src_d;
    end
  end

  logic [AXES-1:0] act_en_w;
  assign act_en_w = act_cfg.en;

  assert_act_after_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_s)
    act_evt_o |-> $past(smp_valid_i));

  assert_quiet_after_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_s)
    quiet_evt_o |-> $past(smp_valid_i));

  assert_src_from_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_s)
    act_evt_o |-> ((act_src_o != '0) && ((act_src_o & ~$past(act_en_w)) == '0)));

  assert_no_axes_no_act_R11: assert property (@(posedge clk_i) disable iff (!rst_s)
    ($past(act_en_w) == '0) |-> !act_evt_o);
endmodule

// File: tb/mad_motion_detect_tb.sv
`timescale 1ns/1ps
module mad_motion_detect_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [11:0] sx = '0, sy = '0, sz = '0;
  logic [7:0]        cfg = 8'h00;
  logic [7:0]        athr = 8'd4, qthr = 8'd2, qsecs = 8'd0;
  logic              tick = 1'b0;
  logic              act_evt, quiet_evt;
  logic [2:0]        act_src;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mad_motion_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .motion_cfg_i(cfg), .act_thr_i(athr), .quiet_thr_i(qthr),
    .quiet_secs_i(qsecs), .sec_tick_i(tick),
    .act_evt_o(act_evt), .quiet_evt_o(quiet_evt), .act_src_o(act_src)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // strobe one sample; returns at the falling edge after the capturing edge
  task automatic smp(input int x, input int y, input int z);
    @(negedge clk);
    smp_valid = 1'b1; sx = x[11:0]; sy = y[11:0]; sz = z[11:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic sec();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R8 tick alone", quiet_evt, 0);
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); cfg = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 act", act_evt, 0);
    chk("R1 quiet", quiet_evt, 0);
    chk("R1 src", act_src, 0);
  endtask

  task automatic t_act_dc();
    athr = 8'd4;               // limit 64
    set_cfg(8'h70);            // R4: activity dc, X Y Z
    smp(64, 0, 0);   chk("R2 equal", act_evt, 0);
    smp(65, 0, 0);   chk("R2 over", act_evt, 1); chk("R3 src X", act_src, 3'b100);
    @(negedge clk);  chk("R12 one cycle", act_evt, 0); chk("R3 held", act_src, 3'b100);
    smp(0, -70, 0);  chk("R5 negative", act_evt, 1); chk("R3 src Y", act_src, 3'b010);
    set_cfg(8'h30);            // X deselected
    smp(500, 10, -20); chk("R3 unselected", act_evt, 0); chk("R3 held2", act_src, 3'b010);
    smp(0, 0, -65);  chk("R4 Z", act_evt, 1); chk("R3 src Z", act_src, 3'b001);
    smp(-2048, 2047, 0); chk("R3 mask", act_src, 3'b010);
  endtask

  task automatic t_act_ac();
    set_cfg(8'hF0);
    smp(1000, 0, 0); chk("R6 capture", act_evt, 0);
    smp(1050, 0, 0); chk("R6 diff50", act_evt, 0);
    smp(1070, 0, 0); chk("R6 diff70", act_evt, 1); chk("R6 src", act_src, 3'b100);
    smp(900, 0, 0);  chk("R6 diff100", act_evt, 1);
    set_cfg(8'h00);
    set_cfg(8'hF0);
    smp(900, 0, 0);  chk("R6 recapture", act_evt, 0);
    smp(960, 0, 0);  chk("R6 new ref60", act_evt, 0);
    smp(830, 0, 0);  chk("R6 new ref70", act_evt, 1);
    set_cfg(8'h80);
    smp(2000, 2000, 2000); chk("R11 none selected", act_evt, 0);
  endtask

  task automatic t_quiet_zero();
    qthr = 8'd2; qsecs = 8'd0; athr = 8'd10;   // quiet limit 32, activity 160
    set_cfg(8'h07);
    smp(32, 0, 0);    chk("R7 equal is loud", quiet_evt, 0);
    smp(31, -31, 0);  chk("R9 immediate", quiet_evt, 1);
    @(negedge clk);   chk("R12 quiet one cycle", quiet_evt, 0);
    smp(0, 0, 0);     chk("R10 disarmed", quiet_evt, 0);
    set_cfg(8'h77);
    smp(200, 0, 0);   chk("R10 rearm act", act_evt, 1); chk("R7 loud", quiet_evt, 0);
    smp(5, 5, 5);     chk("R10 rearmed", quiet_evt, 1); chk("R2 no act", act_evt, 0);
  endtask

  task automatic t_quiet_timer();
    qsecs = 8'd3;
    smp(200, 0, 0);   chk("R10 rearm", act_evt, 1);
    sec();                                   // before any quiet sample: no count
    smp(0, 0, 0);     chk("R8 cnt0", quiet_evt, 0);
    sec(); sec();
    smp(0, 0, 0);     chk("R8 cnt2", quiet_evt, 0);
    sec();
    smp(0, 0, 0);     chk("R8 cnt3", quiet_evt, 1);
    smp(200, 0, 0);   chk("R10 rearm2", act_evt, 1);
    smp(0, 0, 0);     chk("R8 start", quiet_evt, 0);
    sec(); sec();
    smp(40, 0, 0);    chk("R7 loud restart", quiet_evt, 0); chk("R2 below act", act_evt, 0);
    smp(0, 0, 0);     chk("R7 after restart", quiet_evt, 0);
    sec(); sec();
    smp(0, 0, 0);     chk("R7 cnt2 again", quiet_evt, 0);
    sec();
    smp(0, 0, 0);     chk("R8 cnt3 again", quiet_evt, 1);
  endtask

  task automatic t_quiet_ac();
    qsecs = 8'd0;
    set_cfg(8'h70);
    smp(200, 0, 0);   chk("R10 rearm3", act_evt, 1);
    set_cfg(8'h0C);                          // quiet ac, X only
    smp(1000, 2000, 0); chk("R6 quiet capture", quiet_evt, 1);
    set_cfg(8'h4C);
    smp(1040, 0, 0);  chk("R6 act dc", act_evt, 1); chk("R6 quiet diff40", quiet_evt, 0);
    set_cfg(8'h0C);
    smp(1020, 0, 0);  chk("R6 quiet diff20", quiet_evt, 1); chk("R11 act off", act_evt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_act_dc();
    t_act_ac();
    t_quiet_zero();
    t_quiet_timer();
    t_quiet_ac();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule